// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block turns the single digital output of an analog comparator into a maskable interrupt request. The comparator output is asynchronous to the system clock, so it first passes through a two-flop synchronizer. An edge-detection state machine then watches the synchronized level and reports the event picked by two mode bits: any toggle, a falling edge or a rising edge. A detected event sets a sticky pending flag. The flag is cleared when the CPU acknowledges the interrupt vector, or when software writes a one to the flag's bit.

Software reaches the block through two byte-wide registers chosen by a one-bit select. The control/status register holds the flag, the local enable and the mode. The input-disable register masks the read-back of six pin inputs: two comparator input pins and four ADC input pins. The interrupt request is raised only when the flag, the local enable and the CPU's global enable are all set.

The edge machine has two states. `LVL_LOW` means the tracked level is low and `LVL_HIGH` means it is high. It moves to `LVL_HIGH` when the tracked level is 1 and back to `LVL_LOW` when it is 0. The tracked level is the inverted synchronized output in falling mode and the plain synchronized output in every other mode. The flag machine also has two states. It goes from `FLG_CLEAR` to `FLG_PENDING` on an event. It goes from `FLG_PENDING` back to `FLG_CLEAR` on a clear when no event arrives in the same cycle.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset the interrupt request is low, both registers read 0x00, no pin is masked, the mode is 00 and the interrupt is disabled.
- R2: The mode field selects the event. Code 00 is any change of the synchronized output, 10 is a 1-to-0 change and 11 is a 0-to-1 change. A change on `cmp_out` is visible as the flag in the third rising clock edge after the change and not in the second.
- R3: Mode code 01 is reserved and never sets the flag, whatever `cmp_out` does.
- R4: `irq` is high exactly when the flag, the enable bit and `global_ie` are all 1.
- R5: A high `vec_ack` at a clock edge clears the flag.
- R6: A write to register 0 with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged.
- R7: When an event and a clear (acknowledge or write-one) fall on the same edge, the flag ends up set.
- R8: Register 0 (`reg_sel`=0) has the flag at bit 4 (read-only apart from the write-one clear), the enable at bit 3 and the mode at bits 1:0. Bits 7:5 and bit 2 read zero.
- R9: Register 1 (`reg_sel`=1) holds six disable bits at 5:0, and bits 7:6 read zero. Bits 5:4 are the two comparator input pins and bits 3:0 are the ADC pins. `pin_rd[i]` equals `pin_raw[i]` when bit i is 0 and is 0 when bit i is 1.
- R10: A change of mode is itself an event whenever the tracked level steps as R2's rules define it. For example, changing from 11 to 10 while the output is low sets the flag on the next edge, and the change is not suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_out | input | 1 | Asynchronous comparator output |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control/status, 1 selects input-disable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| global_ie | input | 1 | CPU global interrupt enable |
| vec_ack | input | 1 | CPU acknowledge of the comparator vector |
| irq | output | 1 | Interrupt request |
| pin_raw | input | 6 | Raw pin input values |
| pin_rd | output | 6 | Pin read-back after masking |

## Verification
A wrong edge-machine state shows up as a flag that is set or missing in `rd_data` bit 4 on the third edge after a `cmp_out` change, or on the edge right after a mode write. The sweep compares every mode against every starting level at that exact edge. A flag machine stuck in one state shows up at the first acknowledge, write-one clear or event that should have moved it, and also at `irq` once both enables are set. Register or masking faults appear as a combinational mismatch on `rd_data` or `pin_rd` in the same cycle the register is read.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
    localparam int REG_W    = 8;
    localparam int PIN_W    = 6;
    localparam int FLAG_BIT = 4;
    localparam int IE_BIT   = 3;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } trig_mode_e;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } lvl_state_e;

    typedef enum logic {
        FLG_CLEAR,
        FLG_PENDING
    } flag_state_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmp_edge_fsm.sv
module cmp_edge_fsm
    import cmp_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_sync,
    input  trig_mode_e mode,
    output logic       evt
);
    lvl_state_e state_q, state_d;
    logic       tracked;

    // Falling mode tracks the inverted level, so every mode except
    // toggle reduces to a rise of the tracked level.
    assign tracked = (mode == MODE_FALL) ? ~lvl_sync : lvl_sync;

    always_comb begin
        state_d = tracked ? LVL_HIGH : LVL_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            LVL_LOW:  evt = tracked && (mode != MODE_RSVD);
            LVL_HIGH: evt = !tracked && (mode == MODE_TOGGLE);
            default:  evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_flag_fsm.sv
module cmp_flag_fsm
    import cmp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_wr,
    input  logic ack,
    input  logic ie,
    input  logic gie,
    output logic flag,
    output logic irq
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (evt) state_d = FLG_PENDING;
            FLG_PENDING: if (!evt && (clr_wr || ack)) state_d = FLG_CLEAR;
            default:     state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLG_PENDING);
        irq  = flag && ie && gie;
    end
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             flag,
    input  logic [PIN_W-1:0] pin_raw,
    output trig_mode_e       mode,
    output logic             ie,
    output logic             clr_wr,
    output logic [PIN_W-1:0] dis,
    output logic [REG_W-1:0] rd_data,
    output logic [PIN_W-1:0] pin_rd
);
    localparam int DIS_PAD = REG_W - PIN_W;

    logic wr_ctrl, wr_dis;

    assign wr_ctrl = wr_en && !reg_sel;
    assign wr_dis  = wr_en &&  reg_sel;
    assign clr_wr  = wr_ctrl && wr_data[FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MODE_TOGGLE;
            ie   <= 1'b0;
        end else if (wr_ctrl) begin
            mode <= trig_mode_e'(wr_data[1:0]);
            ie   <= wr_data[IE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dis <= '0;
        else if (wr_dis) dis <= wr_data[PIN_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel) begin
            rd_data = {{DIS_PAD{1'b0}}, dis};
        end else begin
            rd_data[FLAG_BIT] = flag;
            rd_data[IE_BIT]   = ie;
            rd_data[1:0]      = mode;
        end
    end

    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_gate
            assign pin_rd[i] = pin_raw[i] & ~dis[i];
        end
    endgenerate
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_out,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             global_ie,
    input  logic             vec_ack,
    output logic             irq,
    input  logic [PIN_W-1:0] pin_raw,
    output logic [PIN_W-1:0] pin_rd
);
    logic             lvl_sync;
    logic             evt;
    logic             flag;
    logic             ie;
    logic             clr_wr;
    trig_mode_e       mode;
    logic [PIN_W-1:0] dis;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_out),
        .q_sync  (lvl_sync)
    );

    cmp_edge_fsm u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_sync (lvl_sync),
        .mode     (mode),
        .evt      (evt)
    );

    cmp_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr_wr (clr_wr),
        .ack    (vec_ack),
        .ie     (ie),
        .gie    (global_ie),
        .flag   (flag),
        .irq    (irq)
    );

    cmp_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .flag    (flag),
        .pin_raw (pin_raw),
        .mode    (mode),
        .ie      (ie),
        .clr_wr  (clr_wr),
        .dis     (dis),
        .rd_data (rd_data),
        .pin_rd  (pin_rd)
    );
endmodule

// File: rtl/cmp_irq_chk.sv
module cmp_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       reg_sel,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       global_ie,
    input logic       vec_ack,
    input logic       irq,
    input logic [5:0] pin_rd,
    input logic [5:0] dis,
    input logic [1:0] mode,
    input logic       evt,
    input logic       flag,
    input logic       ie
);
    // R4: request only with all three conditions
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ie && global_ie));

    // R5: acknowledge clears when no event competes
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !evt) |=> !flag);

    // R6: write-one clears when no event competes
    a_r6_wr_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_data[4] && !evt) |=> !flag);

    // R7: an event always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    // R2: flag only rises after an event
    a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(evt));

    // R3: reserved mode is silent
    a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> !evt);

    // R8: reserved control bits read zero
    a_r8_ctrl_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rd_data[7:5] == 3'b000 && !rd_data[2]));

    // R9: masked pins read zero
    a_r9_pin_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd & dis) == 6'b0);
endmodule

bind cmp_irq_ctrl cmp_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .global_ie (global_ie),
    .vec_ack   (vec_ack),
    .irq       (irq),
    .pin_rd    (pin_rd),
    .dis       (dis),
    .mode      (mode),
    .evt       (evt),
    .flag      (flag),
    .ie        (ie)
);

// File: tb/tb_cmp_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cmp_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_out = 1'b0;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       global_ie = 1'b0;
    logic       vec_ack = 1'b0;
    logic       irq;
    logic [5:0] pin_raw = 6'h00;
    logic [5:0] pin_rd;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .wr_en(wr_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .global_ie(global_ie), .vec_ack(vec_ack), .irq(irq),
        .pin_raw(pin_raw), .pin_rd(pin_rd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; reg_sel = 1'b0;
    endtask

    function automatic logic flag_now();
        return rd_data[4];
    endfunction

    function automatic logic exp_evt(input logic [1:0] m, input logic a, input logic b);
        case (m)
            2'b00:   return a != b;
            2'b10:   return a & ~b;
            2'b11:   return ~a & b;
            default: return 1'b0;
        endcase
    endfunction

    // settle after a mode write, then clear any mode-change event
    task automatic arm(input logic [1:0] m, input logic lvl);
        @(negedge clk);
        cmp_out = lvl;
        repeat (4) @(negedge clk);
        wr(1'b0, {3'b000, 1'b0, 2'b00, m});
        repeat (2) @(negedge clk);
        wr(1'b0, {3'b000, 1'b1, 2'b00, m});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", rd_data, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        reg_sel = 1'b1; #0.1;
        check("R1 dis", rd_data, 8'h00);
        reg_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        pin_raw = 6'h3F; #0.1;
        check("R1 pins", {2'b0, pin_rd}, 8'h3F);

        // R2/R3 sweep all modes x start levels
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                arm(m[1:0], s[0]);
                check("R2 armed clear", {7'b0, flag_now()}, 8'h00);
                @(negedge clk);
                cmp_out = ~s[0];
                repeat (2) @(negedge clk);
                check("R2 not yet at edge 2", {7'b0, flag_now()}, 8'h00);
                @(negedge clk);
                check(m == 1 ? "R3 reserved quiet" : "R2 edge select",
                      {7'b0, flag_now()}, {7'b0, exp_evt(m[1:0], s[0], ~s[0])});
            end
        end

        // R10 mode change 11 -> 10 with output low creates an event
        arm(2'b11, 1'b0);
        wr(1'b0, 8'h02);
        @(negedge clk);
        check("R10 mode change event", {7'b0, flag_now()}, 8'h01);

        // R6 write zero to flag keeps it, write one clears
        wr(1'b0, 8'h02);
        check("R6 write zero keeps", {7'b0, flag_now()}, 8'h01);
        wr(1'b0, 8'h12);
        check("R6 write one clears", {7'b0, flag_now()}, 8'h00);

        // R4 sweep flag x ie x gie; mode 11, output low, no events
        arm(2'b11, 1'b0);
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 2; e++) begin
                for (int g = 0; g < 2; g++) begin
                    wr(1'b0, {3'b000, 1'b1, e[0], 3'b011});
                    if (f == 1) begin
                        cmp_out = 1'b1;
                        repeat (3) @(negedge clk);
                        cmp_out = 1'b0;
                        repeat (3) @(negedge clk);
                    end
                    global_ie = g[0]; #0.1;
                    check("R4 irq", {7'b0, irq}, {7'b0, f[0] & e[0] & g[0]});
                    global_ie = 1'b0;
                end
            end
        end

        // R8 control layout
        wr(1'b0, 8'hFF); #0.1;
        check("R8 ctrl layout", rd_data, 8'h0B);

        // R5 acknowledge clears
        arm(2'b11, 1'b0);
        cmp_out = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 set before ack", {7'b0, flag_now()}, 8'h01);
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        check("R5 ack clears", {7'b0, flag_now()}, 8'h00);

        // R7 event coinciding with ack and with write-one
        arm(2'b11, 1'b0);
        cmp_out = 1'b1;
        repeat (2) @(negedge clk);
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        check("R7 set beats ack", {7'b0, flag_now()}, 8'h01);
        arm(2'b11, 1'b0);
        cmp_out = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h13;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        check("R7 set beats write-one", {7'b0, flag_now()}, 8'h01);

        // R9 disable register sweep
        for (int d = 0; d < 64; d++) begin
            wr(1'b1, {2'b11, d[5:0]});
            pin_raw = 6'h3F ^ d[5:0] ^ 6'h15;
            reg_sel = 1'b1; #0.1;
            check("R9 dis readback", rd_data, {2'b00, d[5:0]});
            check("R9 pin gate", {2'b0, pin_rd}, {2'b0, pin_raw & ~d[5:0]});
            reg_sel = 1'b0;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule